// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Aggregator

This block gathers the interrupt sources of a PCIe root-port bridge into one 32-bit status word and raises a single level interrupt towards the host processor. Six root-complex event pulses are captured as sticky bits: completion timeout, PM_PME received, PME_TO_ACK received, correctable, non-fatal and fatal error messages. The four legacy INTx lines are level inputs, and their status bits track the line levels.

Software reads the status word, services the sources it finds, and writes the same value back to clear the event bits it handled. Per-bit blocking is held in a read-only mask word. That word changes only through two write-only command words. One unblocks the bits written as 1 and the other blocks them, so software never needs a read-modify-write sequence. Every source starts blocked after reset. The register port uses word addresses and single-cycle requests, and read data returns one cycle after the request.

Top module: `rp_irq_aggregator`

## Requirements
- R1: After reset the mask word reads 0xFFFFFFFF, the status word reads 0, `irq_out` is 0 and `bus_rvalid` is 0.
- R2: A read request (`bus_req`=1, `bus_we`=0) gives `bus_rvalid`=1 on the next cycle, with the register value as it stood at the request edge. Non-read cycles give `bus_rvalid`=0. Reads of the enable word, the disable word or any unmapped address return 0. With the default parameters the word addresses are status 0x130, mask 0x131, enable 0x132 and disable 0x133.
- R3: A one-cycle pulse on `evt_pulse[k]` sets a status bit on the next edge, and that bit stays set. The mapping is k=0 to bit 15, k=1 to bit 24, k=2 to bit 25, k=3 to bit 26, k=4 to bit 27 and k=5 to bit 28. Status bits that belong to no event and no INTx line always read 0.
- R4: Writing the status word clears every event bit written as 1. Bits written as 0 keep their value.
- R5: If an event pulse arrives in the same cycle as a write that clears its bit, the bit is set after that edge.
- R6: INTx line i maps to status bit 16+2i, so lines 0 to 3 use bits 16, 18, 20 and 22. Each of these bits equals the line level sampled at the previous edge. A write to the status word has no effect on them, and bits 17, 19, 21 and 23 read 0.
- R7: Writing the enable word clears each mask bit written as 1. Bits written as 0 keep their value.
- R8: Writing the disable word sets each mask bit written as 1. Bits written as 0 keep their value.
- R9: A write to the mask word itself has no effect on the mask.
- R10: `irq_out` is high in a cycle exactly when, one edge earlier, some status bit was 1 while its mask bit was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| evt_pulse | input | 6 | Root-complex event pulses |
| intx_lvl | input | 4 | Legacy INTx levels, lines 0 to 3 |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The bench uses the default parameters: ADDR_W of 10 and word addresses 0x130 to 0x133. Address 0x134 and address 0 are therefore unmapped, and the random traffic reaches them freely. With a 10-bit address and four closely spaced register words, random accesses land on each register often. This brings same-cycle collisions within reach: an event pulse arriving with a status clear, and INTx level changes arriving with writes to the status word.

// File: rtl/rp_irqagg_pkg.sv
`timescale 1ns/1ps
package rp_irqagg_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_EVT   = 6;
    localparam int NUM_INTX  = 4;
    localparam int INTX_BASE = 16;
    localparam int INTX_STEP = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_ENABLE,
        SEL_DISABLE
    } reg_sel_e;

    // Status bit position of event input k
    function automatic int evt_pos(input int k);
        case (k)
            0:       return 15;
            1:       return 24;
            2:       return 25;
            3:       return 26;
            4:       return 27;
            default: return 28;
        endcase
    endfunction

    // Status bit position of INTx line i
    function automatic int intx_pos(input int i);
        return INTX_BASE + INTX_STEP * i;
    endfunction

endpackage

// File: rtl/rp_irqagg_decode.sv
`timescale 1ns/1ps
module rp_irqagg_decode
    import rp_irqagg_pkg::*;
#(
    parameter int          ADDR_W       = 10,
    parameter int unsigned STATUS_ADDR  = 'h130,
    parameter int unsigned MASK_ADDR    = 'h131,
    parameter int unsigned ENABLE_ADDR  = 'h132,
    parameter int unsigned DISABLE_ADDR = 'h133
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == ADDR_W'(STATUS_ADDR))
            sel = SEL_STATUS;
        else if (addr == ADDR_W'(MASK_ADDR))
            sel = SEL_MASK;
        else if (addr == ADDR_W'(ENABLE_ADDR))
            sel = SEL_ENABLE;
        else if (addr == ADDR_W'(DISABLE_ADDR))
            sel = SEL_DISABLE;
        else
            sel = SEL_NONE;
    end

endmodule

// File: rtl/rp_irqagg_status.sv
`timescale 1ns/1ps
module rp_irqagg_status
    import rp_irqagg_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int NEVT = NUM_EVT,
    parameter int NINT = NUM_INTX
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] evt_pulse,
    input  logic [NINT-1:0] intx_lvl,
    input  logic            clr_en,
    input  logic [W-1:0]    clr_bits,
    output logic [W-1:0]    status
);

    logic [NEVT-1:0] evt_q;
    logic [NINT-1:0] intx_q;
    logic [NEVT-1:0] evt_clr;

    // Clear request per event, picked from its status bit position
    always_comb begin
        for (int k = 0; k < NEVT; k++)
            evt_clr[k] = clr_en & clr_bits[evt_pos(k)];
    end

    // Sticky event capture: a new pulse wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= '0;
        else
            evt_q <= evt_pulse | (evt_q & ~evt_clr);
    end

    // INTx levels sampled once, never cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)
            intx_q <= '0;
        else
            intx_q <= intx_lvl;
    end

    // Place the sources into the status word
    always_comb begin
        status = '0;
        for (int k = 0; k < NEVT; k++)
            status[evt_pos(k)] = evt_q[k];
        for (int i = 0; i < NINT; i++)
            status[intx_pos(i)] = intx_q[i];
    end

endmodule

// File: rtl/rp_irqagg_mask.sv
`timescale 1ns/1ps
module rp_irqagg_mask
    import rp_irqagg_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic         dis_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);

    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (en_wr)
            mask_q <= mask_q & ~wdata;
        else if (dis_wr)
            mask_q <= mask_q | wdata;
    end

    assign mask = mask_q;

endmodule

// File: rtl/rp_irq_aggregator.sv
`timescale 1ns/1ps
module rp_irq_aggregator
    import rp_irqagg_pkg::*;
#(
    parameter int          ADDR_W       = 10,
    parameter int unsigned STATUS_ADDR  = 'h130,
    parameter int unsigned MASK_ADDR    = 'h131,
    parameter int unsigned ENABLE_ADDR  = 'h132,
    parameter int unsigned DISABLE_ADDR = 'h133
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic                bus_rvalid,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_EVT-1:0]  evt_pulse,
    input  logic [NUM_INTX-1:0] intx_lvl,
    output logic                irq_out
);

    reg_sel_e          sel;
    logic              wr, rd;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] rd_mux;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic              irq_q;

    assign wr = bus_req &  bus_we;
    assign rd = bus_req & ~bus_we;

    rp_irqagg_decode #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR),
        .MASK_ADDR   (MASK_ADDR),
        .ENABLE_ADDR (ENABLE_ADDR),
        .DISABLE_ADDR(DISABLE_ADDR)
    ) u_decode (
        .addr(bus_addr),
        .sel (sel)
    );

    rp_irqagg_status #(
        .W   (DATA_W),
        .NEVT(NUM_EVT),
        .NINT(NUM_INTX)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_pulse(evt_pulse),
        .intx_lvl (intx_lvl),
        .clr_en   (wr && sel == SEL_STATUS),
        .clr_bits (bus_wdata),
        .status   (status)
    );

    rp_irqagg_mask #(
        .W(DATA_W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .en_wr (wr && sel == SEL_ENABLE),
        .dis_wr(wr && sel == SEL_DISABLE),
        .wdata (bus_wdata),
        .mask  (mask)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_mux = status;
            SEL_MASK:   rd_mux = mask;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd;
            rdata_q  <= rd ? rd_mux : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(status & ~mask);
    end

    assign bus_rvalid = rvalid_q;
    assign bus_rdata  = rdata_q;
    assign irq_out    = irq_q;

endmodule

// File: rtl/rp_irqagg_checker.sv
`timescale 1ns/1ps
module rp_irqagg_checker
    import rp_irqagg_pkg::*;
#(
    parameter int          ADDR_W       = 10,
    parameter int unsigned STATUS_ADDR  = 'h130,
    parameter int unsigned MASK_ADDR    = 'h131,
    parameter int unsigned ENABLE_ADDR  = 'h132,
    parameter int unsigned DISABLE_ADDR = 'h133
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_rvalid,
    input logic [NUM_EVT-1:0]  evt_pulse,
    input logic [NUM_INTX-1:0] intx_lvl,
    input logic [DATA_W-1:0]   status,
    input logic [DATA_W-1:0]   mask,
    input logic                irq_out
);

    logic wr_status, wr_en, wr_dis;
    assign wr_status = bus_req && bus_we && bus_addr == ADDR_W'(STATUS_ADDR);
    assign wr_en     = bus_req && bus_we && bus_addr == ADDR_W'(ENABLE_ADDR);
    assign wr_dis    = bus_req && bus_we && bus_addr == ADDR_W'(DISABLE_ADDR);

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid); // R2
    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid); // R2
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse[0] |=> status[15]); // R5
    AST_EVT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status[28] && !(wr_status && bus_wdata[28])) |=> status[28]); // R4
    AST_INTX_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> status[22] == $past(intx_lvl[3])); // R6
    AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_wdata[16]) |=> !mask[16]); // R7
    AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dis && bus_wdata[24]) |=> mask[24]); // R8
    AST_MASK_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || wr_dis) |=> $stable(mask)); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |=> !irq_out); // R10

endmodule

bind rp_irq_aggregator rp_irqagg_checker #(
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR),
    .MASK_ADDR   (MASK_ADDR),
    .ENABLE_ADDR (ENABLE_ADDR),
    .DISABLE_ADDR(DISABLE_ADDR)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rvalid(bus_rvalid),
    .evt_pulse (evt_pulse),
    .intx_lvl  (intx_lvl),
    .status    (status),
    .mask      (mask),
    .irq_out   (irq_out)
);

// File: tb/test_rp_irq_aggregator.sv
`timescale 1ns/1ps
module test_rp_irq_aggregator;

    localparam logic [9:0] A_STAT = 10'h130;
    localparam logic [9:0] A_MASK = 10'h131;
    localparam logic [9:0] A_EN   = 10'h132;
    localparam logic [9:0] A_DIS  = 10'h133;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_pulse = '0;
    logic [3:0]  intx_lvl = '0;
    logic        irq_out;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] m_status, m_mask, last_rd;
    logic [3:0]  cur_intx;

    always #4 clk = ~clk;

    rp_irq_aggregator i_rp_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .intx_lvl(intx_lvl),
        .irq_out(irq_out)
    );

    function automatic int ev_bit(input int k);
        int tbl [6] = '{15, 24, 25, 26, 27, 28};
        return tbl[k];
    endfunction

    function automatic logic [31:0] model_read(input logic [9:0] a);
        if (a == A_STAT) return m_status;
        if (a == A_MASK) return m_mask;
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic step(input logic req, input logic we, input logic [9:0] a,
                        input logic [31:0] wd, input logic [5:0] ev, input logic [3:0] ix);
        logic        is_rd, irq_n, clr;
        logic [31:0] exp_rd, nstat;
        bus_req = req; bus_we = we; bus_addr = a; bus_wdata = wd;
        evt_pulse = ev; intx_lvl = ix; cur_intx = ix;
        @(posedge clk);
        is_rd  = req && !we;
        exp_rd = is_rd ? model_read(a) : 32'h0;
        irq_n  = |(m_status & ~m_mask);
        clr    = req && we && a == A_STAT;
        nstat  = '0;
        for (int k = 0; k < 6; k++)
            nstat[ev_bit(k)] = ev[k] | (m_status[ev_bit(k)] & ~(clr & wd[ev_bit(k)]));
        for (int i = 0; i < 4; i++)
            nstat[16 + 2 * i] = ix[i];
        m_status = nstat;
        if (req && we && a == A_EN)  m_mask = m_mask & ~wd;
        if (req && we && a == A_DIS) m_mask = m_mask | wd;
        @(negedge clk);
        check("R2 rvalid", {31'b0, bus_rvalid}, {31'b0, is_rd});
        if (is_rd) begin
            check("R2 rdata", bus_rdata, exp_rd);
            last_rd = bus_rdata;
        end
        check("R10 irq", {31'b0, irq_out}, {31'b0, irq_n});
        bus_req = 1'b0; evt_pulse = '0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d, 6'b0, cur_intx);
    endtask

    task automatic rd(input logic [9:0] a);
        step(1'b1, 1'b0, a, 32'h0, 6'b0, cur_intx);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 10'h0, 32'h0, 6'b0, cur_intx);
    endtask

    initial begin
        #(8 * 200000);
        nerr++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        m_status = '0; m_mask = '1; last_rd = '0; cur_intx = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        check("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
        rd(A_MASK);  check("R1 mask", last_rd, 32'hFFFF_FFFF);
        rd(A_STAT);  check("R1 status", last_rd, 32'h0);
        // R3 with every source blocked: no interrupt
        step(1'b0, 1'b0, 10'h0, 32'h0, 6'b000001, 4'h0);
        idle();
        check("R10 masked", {31'b0, irq_out}, 32'h0);
        rd(A_STAT);  check("R3 evt0", last_rd, 32'h0000_8000);
        // R7: unblock everything
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_MASK);  check("R7 enable", last_rd, 32'h0);
        check("R10 unmasked", {31'b0, irq_out}, 32'h1);
        // R3: remaining events
        step(1'b0, 1'b0, 10'h0, 32'h0, 6'b111110, 4'h0);
        rd(A_STAT);  check("R3 all events", last_rd, 32'h1F00_8000);
        // R4: write zero has no effect, write one clears
        wr(A_STAT, 32'h0);
        rd(A_STAT);  check("R4 zero write", last_rd, 32'h1F00_8000);
        wr(A_STAT, 32'h1F00_8000);
        rd(A_STAT);  check("R4 clear", last_rd, 32'h0);
        idle();
        check("R10 drops", {31'b0, irq_out}, 32'h0);
        // R5: pulse with same-cycle clear
        step(1'b0, 1'b0, 10'h0, 32'h0, 6'b100000, 4'h0);
        step(1'b1, 1'b1, A_STAT, 32'h1000_0000, 6'b100000, 4'h0);
        rd(A_STAT);  check("R5 collision", last_rd, 32'h1000_0000);
        wr(A_STAT, 32'hFFFF_FFFF);
        // R6: INTx levels
        step(1'b0, 1'b0, 10'h0, 32'h0, 6'b0, 4'hF);
        rd(A_STAT);  check("R6 intx on", last_rd, 32'h0055_0000);
        wr(A_STAT, 32'h00FF_0000);
        rd(A_STAT);  check("R6 not clearable", last_rd, 32'h0055_0000);
        step(1'b0, 1'b0, 10'h0, 32'h0, 6'b0, 4'b0100);
        rd(A_STAT);  check("R6 intx2", last_rd, 32'h0010_0000);
        // R8: block bit 20, interrupt falls
        wr(A_DIS, 32'h0010_0000);
        rd(A_MASK);  check("R8 disable", last_rd, 32'h0010_0000);
        check("R10 blocked", {31'b0, irq_out}, 32'h0);
        wr(A_DIS, 32'h0);
        rd(A_MASK);  check("R8 zero write", last_rd, 32'h0010_0000);
        wr(A_EN, 32'h0);
        rd(A_MASK);  check("R7 zero write", last_rd, 32'h0010_0000);
        // R9: mask word not writable
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK);  check("R9 read-only", last_rd, 32'h0010_0000);
        // R2: enable, disable and unmapped addresses read zero
        rd(A_EN);    check("R2 enable reads 0", last_rd, 32'h0);
        rd(A_DIS);   check("R2 disable reads 0", last_rd, 32'h0);
        rd(10'h134); check("R2 unmapped", last_rd, 32'h0);
        // Random traffic against the model (R2, R10 each step)
        void'($urandom(32'd20250601));
        for (int n = 0; n < 3000; n++) begin
            logic [2:0]  pick;
            logic [9:0]  a;
            logic [5:0]  ev;
            logic [3:0]  ix;
            logic [31:0] d;
            pick = 3'($urandom % 6);
            a  = (pick == 3'd5) ? 10'h0 : 10'h130 + 10'(pick);
            ev = 6'($urandom) & 6'($urandom) & 6'($urandom);
            ix = ($urandom % 8 == 0) ? 4'($urandom) : cur_intx;
            d  = ($urandom % 2 == 0) ? $urandom : (32'h1 << ($urandom % 32));
            step(1'($urandom), 1'($urandom), a, d, ev, ix);
        end
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule